// File: doc/BRIEF.md
# Lazy-Reduction Modular Add/Subtract Chain

This block works through a chain of modular additions and subtractions over a prime modulus MOD that is wider than a native word. The values are split into LIMBS limbs of LIMB_W bits each. A chain arrives on a valid/ready stream. The first beat carries the starting value. Every later beat carries a right operand and a subtract flag. Each step's result becomes the left operand of the next step.

Intermediate results are kept raw, which means they only need to fit in W = LIMBS*LIMB_W bits. They are never reduced fully below MOD. After the beat marked last, the block forms a bound term once, on the final value. The pass flag shows whether the final value is the minimal representative below MOD.

A check-level input selects which values get range checked. The block can check every input and every intermediate result, only the inputs, or only the bound. Any range failure sets an error flag that stays set for the rest of the chain. The finished chain is held on the outputs until the consumer acknowledges it.

Top module: `lazy_add_chain`

## Requirements
- R1: The first beat of a chain loads its value as the running result, and its subtract flag is ignored. A chain whose first beat is also its last returns that value as `res`.
- R2: An add step with running value r and operand b forms t = r + b. If t >= MOD, MOD is subtracted once. The new running value is t mod 2^W.
- R3: A subtract step forms t = r - b. If r < b, MOD is added once. The new running value is t mod 2^W.
- R4: When the chain completes, `bound` equals (res + 2^W - MOD) mod 2^W. `pass` is 1 exactly when res < MOD and `err` is 0.
- R5: `done` rises in the cycle after the last beat is accepted, and stays high until `done_ack` is sampled high. While `done` is high, `in_ready` is 0 and `res` does not change.
- R6: With `mode` = 0 (full checking), `err` is set when any limb of any input has its guard bit set. It is also set when a step's unwrapped value t lies outside [0, 2^W).
- R7: With `mode` = 1 (inputs only), guard bits on inputs set `err`, but a step that wraps does not.
- R8: With `mode` = 2 or 3 (bound only), neither guard bits nor wrapping steps set `err`.
- R9: `err` stays set through the rest of the chain once set. The first beat of the next chain clears it, unless that beat itself fails a check.
- R10: After reset, `in_ready` = 1, `done` = 0 and `err` = 0.
- R11: Limb i of `in_data` occupies bits [i*(LIMB_W+1) +: LIMB_W+1]. Its low LIMB_W bits are value bits i*LIMB_W upward. Its top bit is the guard bit, which marks the limb as out of range, and it never enters the arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Check level: 0 full, 1 inputs only, 2/3 bound only |
| in_valid | input | 1 | Operand beat valid |
| in_ready | output | 1 | Operand beat accepted when high with in_valid |
| in_data | input | LIMBS*(LIMB_W+1) | Operand limbs, each with a guard bit |
| in_sub | input | 1 | Subtract this operand (ignored on first beat) |
| in_last | input | 1 | Final operand of the chain |
| done | output | 1 | Chain result available |
| done_ack | input | 1 | Consumer takes the result |
| res | output | LIMBS*LIMB_W | Final raw result |
| bound | output | LIMBS*LIMB_W | Bound term res + 2^W - MOD |
| pass | output | 1 | Result below MOD and no range error |
| err | output | 1 | Sticky range-check error |

## Verification
Every step result is registered at the edge that accepts its beat, so `done`, `res`, `bound`, `pass` and `err` all appear one edge after the last beat is accepted. The bench drives each beat for exactly one rising edge, from falling edge to falling edge. It reads the outputs at the falling edge that follows the last beat, which is half a cycle after they settle and half a cycle before any later edge could change them. For the hold tests it then samples again at further falling edges while `done_ack` stays low.

// File: rtl/lazy_add_chain.sv
module lazy_add_chain #(
  parameter int LIMB_W = 88,
  parameter int LIMBS  = 3,
  parameter logic [LIMB_W*LIMBS-1:0] MOD =
    264'h00_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE_FFFFFC2F
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    mode,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [LIMBS*(LIMB_W+1)-1:0]   in_data,
  input  logic                          in_sub,
  input  logic                          in_last,
  output logic                          done,
  input  logic                          done_ack,
  output logic [LIMB_W*LIMBS-1:0]       res,
  output logic [LIMB_W*LIMBS-1:0]       bound,
  output logic                          pass,
  output logic                          err
);
  localparam int W  = LIMB_W * LIMBS;
  localparam int SW = LIMB_W + 1;

  logic [W-1:0]     in_val, r_q;
  logic [LIMBS-1:0] guard;
  logic             first, fire, chk_in, chk_mid, wrap;
  logic [W+1:0]     t;
  logic [W:0]       ub;

  for (genvar g = 0; g < LIMBS; g++) begin : g_limb
    assign in_val[g*LIMB_W +: LIMB_W] = in_data[g*SW +: LIMB_W];
    assign guard[g] = in_data[g*SW + LIMB_W];
  end

  assign in_ready = !done;
  assign fire     = in_valid && in_ready;
  assign chk_in   = !mode[1];
  assign chk_mid  = (mode == 2'd0);

  always_comb begin
    if (!in_sub) begin
      t = {2'b00, r_q} + {2'b00, in_val};
      if (t >= {2'b00, MOD}) t = t - {2'b00, MOD};
    end else begin
      t = {2'b00, r_q} - {2'b00, in_val};
      if (r_q < in_val) t = t + {2'b00, MOD};
    end
  end
  assign wrap = t[W+1] | t[W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first <= 1'b1;
      done  <= 1'b0;
      r_q   <= '0;
      err   <= 1'b0;
    end else if (done) begin
      if (done_ack) begin
        done  <= 1'b0;
        first <= 1'b1;
      end
    end else if (fire) begin
      first <= 1'b0;
      done  <= in_last;
      if (first) begin
        r_q <= in_val;
        err <= chk_in && (|guard);
      end else begin
        r_q <= t[W-1:0];
        err <= err | (chk_in && (|guard)) | (chk_mid && wrap);
      end
    end
  end

  assign ub    = {1'b0, r_q} + {1'b0, (~MOD) + 1'b1};
  assign res   = r_q;
  assign bound = ub[W-1:0];
  assign pass  = !ub[W] && !err;

  a_r5_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_ack |=> done);
  a_r5_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(in_valid && in_last));
  a_r5_res_stable: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(res));
  a_r4_pass_below: assert property (@(posedge clk) disable iff (!rst_n)
    done && pass |-> (res < MOD));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(fire && first) |=> err);
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fire && mode[1] && !first && !err |=> !err);
endmodule

// File: tb/lazy_add_chain_tb.sv
module lazy_add_chain_tb;
  localparam int LW = 3;
  localparam int LN = 2;
  localparam int W  = LW * LN;
  localparam int TOP = 1 << W;
  localparam int FM = 53;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic in_valid = 1'b0, in_sub = 1'b0, in_last = 1'b0, done_ack = 1'b0;
  logic [LN*(LW+1)-1:0] in_data = '0;
  logic in_ready, done, pass, err;
  logic [W-1:0] res, bound;

  int checks = 0, errors = 0;
  int exp_r = 0;
  bit exp_err = 1'b0;

  always #5 clk = ~clk;

  lazy_add_chain #(.LIMB_W(LW), .LIMBS(LN), .MOD(W'(FM))) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sub(in_sub), .in_last(in_last), .done(done),
    .done_ack(done_ack), .res(res), .bound(bound), .pass(pass), .err(err));

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic beat(input int val, input bit sub, input bit last, input int gmask, input bit first);
    logic [LN*(LW+1)-1:0] d;
    int t;
    bit wr;
    d = '0;
    for (int i = 0; i < LN; i++) begin
      d[i*(LW+1) +: LW] = LW'(val >> (i*LW));
      d[i*(LW+1) + LW]  = gmask[i];
    end
    if (first) begin
      exp_r = val % TOP;
      exp_err = (mode < 2) && (gmask != 0);
    end else begin
      if (!sub) begin
        t = exp_r + val;
        if (t >= FM) t = t - FM;
      end else begin
        t = exp_r - val;
        if (exp_r < val) t = t + FM;
      end
      wr = (t < 0) || (t >= TOP);
      exp_r = ((t % TOP) + TOP) % TOP;
      exp_err = exp_err | ((mode < 2) && (gmask != 0)) | ((mode == 0) && wr);
    end
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sub = sub; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic finish_chain(input string tag);
    check(done == 1'b1, {tag, " R5 done"}, int'(done), 1);
    check(int'(res) == exp_r, {tag, " res"}, int'(res), exp_r);
    check(int'(bound) == (exp_r + TOP - FM) % TOP, {tag, " R4 bound"}, int'(bound), (exp_r + TOP - FM) % TOP);
    check(pass == ((exp_r < FM) && !exp_err), {tag, " R4 pass"}, int'(pass), int'((exp_r < FM) && !exp_err));
    check(err == exp_err, {tag, " err"}, int'(err), int'(exp_err));
    done_ack = 1'b1;
    @(negedge clk);
    done_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R10 ready", int'(in_ready), 1);
    check(done == 1'b0, "R10 done", int'(done), 0);
    check(err == 1'b0, "R10 err", int'(err), 0);

    // R2 R3 R6: full sweep of two-beat chains in full mode
    mode = 2'd0;
    for (int a = 0; a < TOP; a++)
      for (int b = 0; b < TOP; b++)
        for (int s = 0; s < 2; s++) begin
          beat(a, 1'b0, 1'b0, 0, 1'b1);
          beat(b, s[0], 1'b1, 0, 1'b0);
          finish_chain(s[0] ? "R3 sub" : "R2 add");
        end

    // R1: single-beat chains, sign ignored
    mode = 2'd2;
    for (int a = 0; a < TOP; a++) begin
      beat(a, 1'b1, 1'b1, 0, 1'b1);
      finish_chain("R1 single");
    end

    // R7: inputs-only ignores wrap, flags guard
    mode = 2'd1;
    beat(63, 1'b0, 1'b0, 0, 1'b1); beat(60, 1'b0, 1'b1, 0, 1'b0);
    finish_chain("R7 wrap ignored");
    beat(10, 1'b0, 1'b0, 0, 1'b1); beat(5, 1'b1, 1'b1, 2, 1'b0);
    finish_chain("R7 guard");

    // R6 R11: guard on first operand in full mode
    mode = 2'd0;
    beat(20, 1'b0, 1'b0, 1, 1'b1); beat(3, 1'b0, 1'b1, 0, 1'b0);
    finish_chain("R6 R11 guard a");

    // R8: bound-only ignores everything
    mode = 2'd3;
    beat(63, 1'b0, 1'b0, 3, 1'b1); beat(60, 1'b0, 1'b1, 3, 1'b0);
    finish_chain("R8 quiet");

    // R9: sticky within chain, cleared on next chain
    mode = 2'd0;
    beat(4, 1'b0, 1'b0, 0, 1'b1); beat(6, 1'b0, 1'b0, 2, 1'b0); beat(1, 1'b1, 1'b1, 0, 1'b0);
    finish_chain("R9 sticky");
    beat(4, 1'b0, 1'b1, 0, 1'b1);
    finish_chain("R9 cleared");

    // R5: hold until ack, beats refused
    beat(30, 1'b0, 1'b0, 0, 1'b1); beat(7, 1'b0, 1'b1, 0, 1'b0);
    in_valid = 1'b1; in_data = 8'h11; in_last = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R5 held", int'(done), 1);
    check(in_ready == 1'b0, "R5 not ready", int'(in_ready), 0);
    check(int'(res) == exp_r, "R5 res stable", int'(res), exp_r);
    in_valid = 1'b0; in_last = 1'b0;
    finish_chain("R5 ack");
    check(done == 1'b0, "R5 cleared", int'(done), 0);

    // R2 R3 R6 R7: three-beat chains across modes
    for (int m = 0; m < 3; m++) begin
      mode = 2'(m);
      for (int a = 0; a < TOP; a++) begin
        beat(a, 1'b0, 1'b0, 0, 1'b1);
        beat((a*7+3) % TOP, a[0], 1'b0, 0, 1'b0);
        beat((a*13+5) % TOP, a[1], 1'b1, 0, 1'b0);
        finish_chain("R2 R3 chain3");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule